// File: doc/BRIEF.md
# Frequency Threshold Detector

This block reports whether a slow square wave (roughly 1 Hz to 500 Hz) runs faster or slower than a programmable threshold frequency. The input arrives asynchronously, passes through a two-flop synchronizer, and each rising edge restarts a first-stage countdown. That countdown is loaded with one period of the threshold frequency. While edges keep arriving sooner than that, the first stage never expires and its output stays high. Below the threshold it expires once in every input period.

Each expiry is a single-cycle pulse, and it restarts a second countdown. The second countdown is set a little longer than the period of the slowest expected input, so a steady stream of expiries holds it active and merges the pulses into one flat level. The decision output is high only when the first stage is active and the second stage is idle. Both countdowns step on a shared prescaler tick, which is 1 kHz with the default divider on a 250 MHz clock. A processor can rewrite either 16-bit timeout at run time. One instance serves one channel, and the block is replicated for more channels.

Top module: `freq_thresh_det`

## Requirements
- R1: After reset, `stage1_o` and `above_o` are both low and remain low until a qualifying rising edge has been seen.
- R2: A rising edge on `sig_in` that is driven just after clock edge k and held makes `stage1_o` high after clock edge k+3 and not before: two synchronizer flops, then the first-stage load. That load copies the current first-stage timeout.
- R3: A falling edge on `sig_in` never restarts the first stage. An idle first stage stays low after a falling edge.
- R4: While rising edges follow each other sooner than (T1-1) tick periods, `stage1_o` stays high without a gap.
- R5: Both countdowns step only on the prescaler tick, one tick every TICK_DIV clocks. With no further rising edge, `stage1_o` is still high (T1-1)*TICK_DIV clocks after the load and is low by T1*TICK_DIV+1 clocks after it.
- R6: `above_o` is high exactly when the first stage is active and the second stage is idle. For a steady input above threshold it is continuously high.
- R7: For an input below threshold (period longer than T1 ticks and shorter than T2 ticks), `stage1_o` pulses once per input period and `above_o` stays low.
- R8: The second stage is restarted only by the first stage's expiry pulse, which lasts one clock cycle. On that restart it loads the second-stage timeout.
- R9: A write with `cfg_we` high stores `cfg_wdata` as the first-stage timeout when `cfg_sel` is 0 and as the second-stage timeout when `cfg_sel` is 1. A running countdown is not changed by the write. The new value is used from the next restart onward.
- R10: When the input returns above threshold, `above_o` rises once the second-stage timeout has run out without a further first-stage expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous square-wave input |
| cfg_we | input | 1 | Timeout register write strobe |
| cfg_sel | input | 1 | Register select: 0 = first-stage timeout, 1 = second-stage timeout |
| cfg_wdata | input | 16 | Timeout value in prescaler ticks |
| stage1_o | output | 1 | Raw first-stage active level |
| above_o | output | 1 | High when the input frequency is above threshold |

## Verification
The assertions check on every cycle the properties that hold everywhere:
- the synchronized edge and the prescaler tick are never high on two cycles in a row;
- a countdown never rises unless it is restarted, and a restart loads the programmed value;
- an expiry pulse follows a count of one;
- the second stage only starts after a first-stage expiry;
- the decision output implies the first-stage output.

The bench scenarios show the behaviours that depend on input timing:
- the exact three-cycle edge latency;
- the expiry window measured in ticks;
- the steady-high decision for fast input and the steady-low decision for slow input;
- recovery after the second-stage timeout;
- a timeout write that leaves the running countdown alone and governs the next one.

// File: rtl/fthr_pkg.sv
package fthr_pkg;
    localparam int TMR_W    = 16;
    localparam int N_STAGES = 2;
    typedef logic [TMR_W-1:0] tmr_t;
    typedef enum logic { SEL_STAGE1 = 1'b0, SEL_STAGE2 = 1'b1 } cfg_sel_e;
endpackage

// File: rtl/fthr_sync_edge.sv
module fthr_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;

    // R3
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fthr_tick_gen.sv
module fthr_tick_gen #(
    parameter int TICK_DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    assign tick_o = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/fthr_retrig_timer.sv
module fthr_retrig_timer import fthr_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic trig_i,
    input  tmr_t reload_i,
    output logic active_o,
    output logic expire_o
);
    typedef struct packed {
        tmr_t cnt;
        logic exp;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.exp = 1'b0;
        if (trig_i) begin
            st_d.cnt = reload_i;
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.exp = (st_q.cnt == tmr_t'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);
    assign expire_o = st_q.exp;

    // R5
    no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> (st_q.cnt <= $past(st_q.cnt)));
    // R2
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (st_q.cnt == $past(reload_i)));
    // R8
    expire_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> (!active_o && ($past(st_q.cnt) == tmr_t'(1))));
    // R8
    expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
endmodule

// File: rtl/fthr_cfg_regs.sv
module fthr_cfg_regs import fthr_pkg::*; #(
    parameter int T1_DEFAULT = 20,
    parameter int T2_DEFAULT = 1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic sel_i,
    input  tmr_t wdata_i,
    output tmr_t t1_o,
    output tmr_t t2_o
);
    typedef struct packed {
        tmr_t t1;
        tmr_t t2;
    } cfg_st_t;

    localparam cfg_st_t CFG_RST = '{t1: tmr_t'(T1_DEFAULT), t2: tmr_t'(T2_DEFAULT)};

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (cfg_sel_e'(sel_i) == SEL_STAGE1) st_d.t1 = wdata_i;
            else                                 st_d.t2 = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_RST;
        else        st_q <= st_d;
    end

    assign t1_o = st_q.t1;
    assign t2_o = st_q.t2;

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(t1_o) && $stable(t2_o)));
endmodule

// File: rtl/freq_thresh_det.sv
module freq_thresh_det import fthr_pkg::*; #(
    parameter int TICK_DIV   = 250000,
    parameter int T1_DEFAULT = 20,
    parameter int T2_DEFAULT = 1100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [TMR_W-1:0] cfg_wdata,
    output logic             stage1_o,
    output logic             above_o
);
    logic                rise_w;
    logic                tick_w;
    tmr_t                reload_w [N_STAGES];
    logic [N_STAGES-1:0] trig_w;
    logic [N_STAGES-1:0] act_w;
    logic [N_STAGES-1:0] exp_w;

    fthr_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_in),
        .rise_o  (rise_w)
    );

    fthr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    fthr_cfg_regs #(.T1_DEFAULT(T1_DEFAULT), .T2_DEFAULT(T2_DEFAULT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .t1_o    (reload_w[0]),
        .t2_o    (reload_w[1])
    );

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign trig_w[g] = rise_w;
        end else begin : g_chain
            assign trig_w[g] = exp_w[g-1];
        end
        fthr_retrig_timer u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_w),
            .trig_i   (trig_w[g]),
            .reload_i (reload_w[g]),
            .active_o (act_w[g]),
            .expire_o (exp_w[g])
        );
    end

    assign stage1_o = act_w[0];
    assign above_o  = act_w[0] & ~act_w[N_STAGES-1];

    // R6
    above_needs_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        above_o |-> stage1_o);
    // R8
    stage2_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_w[1]) |-> $past(exp_w[0]));
    // R8
    stage2_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_w[N_STAGES-1] |-> !act_w[N_STAGES-1]);
endmodule

// File: tb/freq_thresh_det_tb_top.sv
module freq_thresh_det_tb_top;
    localparam int DIV = 4;
    localparam int T1  = 10;
    localparam int T2  = 30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sig_in;
    logic        cfg_we;
    logic        cfg_sel;
    logic [15:0] cfg_wdata;
    logic        stage1_o;
    logic        above_o;

    int cyc    = 0;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int    due;
        bit    which;
        bit    val;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    freq_thresh_det #(.TICK_DIV(DIV), .T1_DEFAULT(T1), .T2_DEFAULT(T2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .stage1_o  (stage1_o),
        .above_o   (above_o)
    );

    // driver side: expected value of an output, dly cycles from now (which: 0 = stage1_o, 1 = above_o)
    task automatic expect_at(input int dly, input bit which, input bit val, input string tag);
        sb_q.push_back('{cyc + dly, which, val, tag});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops due items and compares
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                bit act;
                act = sb_q[i].which ? above_o : stage1_o;
                checks++;
                if (act !== sb_q[i].val) begin
                    errors++;
                    $display("FAIL %s cycle %0d %s actual=%0b expected=%0b", sb_q[i].tag, cyc,
                             sb_q[i].which ? "above_o" : "stage1_o", act, sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sig_in = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        wait_n(5);
        rst_n = 1'b1;
        // R1: quiet after reset
        expect_at(1, 0, 0, "R1");
        expect_at(1, 1, 0, "R1");
        expect_at(8, 0, 0, "R1");
        wait_n(10);

        // R2 latency, R5 expiry window, R6 decision
        sig_in = 1'b1;
        expect_at(2, 0, 0, "R2");
        expect_at(3, 0, 1, "R2");
        expect_at(4, 1, 1, "R6");
        expect_at(39, 0, 1, "R5");
        expect_at(44, 0, 0, "R5");
        expect_at(46, 1, 0, "R6");
        wait_n(50);
        // R3: falling edge does not restart
        sig_in = 1'b0;
        expect_at(4, 0, 0, "R3");
        expect_at(10, 0, 0, "R3");
        wait_n(200);

        // R4 / R6: fast input, period 20 clocks
        for (int p = 0; p < 15; p++) begin
            sig_in = 1'b1;
            if (p >= 1) begin
                expect_at(1, 0, 1, "R4");
                expect_at(1, 1, 1, "R6");
            end
            wait_n(10);
            sig_in = 1'b0;
            wait_n(10);
        end

        // R7: slow input, period 100 clocks
        for (int p = 0; p < 6; p++) begin
            sig_in = 1'b1;
            if (p >= 1) begin
                expect_at(1, 1, 0, "R7");
                expect_at(20, 0, 1, "R7");
                expect_at(60, 0, 0, "R7");
                expect_at(90, 1, 0, "R7");
            end
            wait_n(50);
            sig_in = 1'b0;
            wait_n(50);
        end

        // R10: back above threshold
        expect_at(5, 1, 0, "R10");
        expect_at(170, 1, 1, "R10");
        for (int p = 0; p < 10; p++) begin
            sig_in = 1'b1;
            wait_n(10);
            sig_in = 1'b0;
            wait_n(10);
        end
        wait_n(300);

        // R9: write mid-count leaves current countdown, governs the next
        sig_in = 1'b1;
        expect_at(3, 0, 1, "R9");
        wait_n(10);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'd40;
        wait_n(1);
        cfg_we = 1'b0;
        expect_at(33, 0, 0, "R9");
        wait_n(19);
        sig_in = 1'b0;
        wait_n(30);
        sig_in = 1'b1;
        expect_at(159, 0, 1, "R9");
        expect_at(164, 0, 0, "R9");
        wait_n(20);
        sig_in = 1'b0;
        wait_n(200);

        while (sb_q.size() != 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule